// File: doc/BRIEF.md
# DC Offset Tracking Loop

This block measures the DC offset carried by a stream of signed converter samples and produces a signed DAC code that an external analog subtractor removes ahead of the converter. For each accepted sample, the block subtracts its current offset estimate from the sample. It scales that difference by a loop gain of 2^-k and adds it into a saturating fixed-point accumulator. The integer part of the accumulator is the estimate, and the estimate drives the DAC port.

The loop adapts only while calibrating, and the converter input is grounded during that time. Calibration starts by itself when reset is released and again each time `cal_start` is pulsed. It ends once the integer error has been zero for a fixed number of consecutive samples. The estimate is then frozen and `cal_done` is raised. A second, purely digital output path delays every sample by a fixed number of valid samples and subtracts the estimate from it. This path gives an offset-free sample stream without any analog feedback.

Top module: `dc_offset_tracker`

## Requirements
- R1: The accumulator has 12 fraction bits below a 12-bit signed integer part. Each sample accepted while calibrating adds (sample − estimate) · 2^(12−k), where the estimate is the accumulator's integer part (floor). `dac_code` shows the updated estimate one cycle after the sample.
- R2: The gain shift k is taken from `shift_k`, with values below 4 treated as 4 and values above 12 treated as 12.
- R3: The accumulator saturates at the ends of its range and never wraps. While calibrating, a positive error never lowers `dac_code` and a negative error never raises it.
- R4: `dac_update` is high for exactly the cycle after each sample that is accepted while calibrating. It stays low in every other cycle.
- R5: While `rst_n` is low at a clock edge, the block clears the accumulator (`dac_code` = 0, midscale), the delay line and the counters. After reset, `busy` = 1, `cal_done` = 0, `dac_update` = 0 and `clean_valid` = 0.
- R6: Calibration runs automatically after reset and restarts on a `cal_start` pulse from any state. The cycle after `cal_start`, the outputs are `busy` = 1 and `cal_done` = 0, and the accumulator keeps its value.
- R7: Calibration completes when 16 consecutive valid samples give an integer error of zero. The outputs then become `cal_done` = 1 and `busy` = 0 one cycle after the 16th sample. A nonzero error restarts the count.
- R8: With `cal_done` high and no `cal_start`, `dac_code` is frozen whatever the samples are, and `cal_done` stays high.
- R9: For valid sample number n (counted from 0 after reset), with n ≥ 4, the block drives `clean_valid` = 1 and `clean_out` = sample(n−4) − estimate on the next cycle. The estimate used is the one held while sample n was presented. `clean_valid` is 0 for samples 0 to 3.
- R10: With a constant input anywhere in −2048..2047, calibration converges exactly: `dac_code` equals the input when `cal_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | Qualifies `sample_in` |
| sample_in | input | 12 | Signed converter sample |
| shift_k | input | 4 | Loop gain shift, clamped to 4..12 |
| cal_start | input | 1 | Pulse to restart calibration |
| dac_code | output | 12 | Signed offset estimate driven to the DAC |
| dac_update | output | 1 | One-cycle strobe after each estimate update |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration complete, estimate frozen |
| clean_valid | output | 1 | Qualifies `clean_out` |
| clean_out | output | 13 | Delayed sample minus estimate, signed |

## Verification
The assertions take two things for granted. First, `cal_start` never arrives in the same cycle as a valid sample. Second, `shift_k` changes only between calibrations, so that the monotonic-step and hold checks compare like with like. The bench pulses `cal_start` with `sample_valid` low, and it sets `shift_k` before each `cal_start` and leaves it unchanged while the loop runs. Stimulus holds the input constant during each convergence, so an exact final value can be expected. It applies ramps only while the estimate is frozen, and the delayed-path result is then a pure function of the sample history.

// File: rtl/dco_pkg.sv
// Package: shared types for the DC offset tracking loop.
// Assumes: nothing beyond IEEE 1800-2017.
package dco_pkg;

    // Calibration controller states: adapting, or frozen after convergence.
    typedef enum logic [0:0] {
        ST_CAL  = 1'b0,
        ST_HOLD = 1'b1
    } cal_state_t;

endpackage

// File: rtl/dco_loop_acc.sv
// Module: error subtractor, gain shifter and saturating integrator.
// Holds a fixed-point accumulator with FRAC fraction bits. Its integer
// part is the offset estimate. While loop_en is high, each valid sample
// adds (sample - estimate) scaled by 2^-k, with k clamped to the range
// SHIFT_MIN..SHIFT_MAX.
// Assumes: SHIFT_MAX fits in SW bits; the sample and estimate share DW.
module dco_loop_acc #(
    parameter int DW        = 12,
    parameter int SHIFT_MIN = 4,
    parameter int SHIFT_MAX = 12,
    parameter int SW        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic signed [DW-1:0] sample_in,
    input  logic [SW-1:0]        shift_k,
    input  logic                 loop_en,
    output logic signed [DW-1:0] est,
    output logic signed [DW:0]   err,
    output logic                 upd
);
    localparam int FRAC = SHIFT_MAX;
    localparam int AW   = DW + FRAC;
    localparam int EW   = DW + 1;
    localparam int XW   = AW + 2;
    localparam logic signed [XW-1:0] ACC_MAX = {{(XW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [XW-1:0] ACC_MIN = ~ACC_MAX;

    logic signed [AW-1:0] acc_q;
    logic [SW-1:0]        shift_eff;
    logic [SW-1:0]        lsh;
    logic signed [XW-1:0] err_x;
    logic signed [XW-1:0] scaled;
    logic signed [XW-1:0] acc_x;
    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] sat;
    logic                 take;

    // Clamp the requested gain shift into the supported window.
    always_comb begin
        if (shift_k < SW'(SHIFT_MIN))      shift_eff = SW'(SHIFT_MIN);
        else if (shift_k > SW'(SHIFT_MAX)) shift_eff = SW'(SHIFT_MAX);
        else                               shift_eff = shift_k;
    end

    // Form the error, align it to the fraction bits and clip the sum.
    always_comb begin
        lsh    = SW'(FRAC) - shift_eff;
        est    = acc_q[AW-1:FRAC];
        err    = {sample_in[DW-1], sample_in} - {est[DW-1], est};
        err_x  = {{(XW-EW){err[EW-1]}}, err};
        scaled = err_x <<< lsh;
        acc_x  = {{(XW-AW){acc_q[AW-1]}}, acc_q};
        sum    = acc_x + scaled;
        if (sum > ACC_MAX)      sat = ACC_MAX;
        else if (sum < ACC_MIN) sat = ACC_MIN;
        else                    sat = sum;
        take   = sample_valid && loop_en;
    end

    // Integrate the scaled error and flag each update for the DAC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= take;
            if (take) acc_q <= sat[AW-1:0];
        end
    end

    // R3
    est_rise_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (err > 0)) |=> (est >= $past(est)));
    // R3
    est_fall_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (err < 0)) |=> (est <= $past(est)));
    // R1
    zero_err_keeps_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (err == 0)) |=> $stable(est));
endmodule

// File: rtl/dco_cal_fsm.sv
// Module: calibration controller.
// Starts in the calibrating state after reset and returns to it on
// cal_start. It counts consecutive valid samples with zero integer error
// and moves to the hold state after WIN of them in a row.
// Assumes: cal_start is not coincident with a valid sample.
module dco_cal_fsm
    import dco_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_start,
    input  logic sample_valid,
    input  logic err_zero,
    output logic loop_en,
    output logic busy,
    output logic cal_done
);
    localparam int CW = $clog2(WIN) + 1;
    localparam int ZW = $clog2(WIN + 1) + 1;

    cal_state_t    state_q;
    logic [CW-1:0] run_q;
    logic [ZW-1:0] zrun_q;

    // Advance the state and the consecutive-zero-error counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CAL;
            run_q   <= '0;
        end else if (cal_start) begin
            state_q <= ST_CAL;
            run_q   <= '0;
        end else if ((state_q == ST_CAL) && sample_valid) begin
            if (!err_zero) begin
                run_q <= '0;
            end else if (run_q == CW'(WIN - 1)) begin
                state_q <= ST_HOLD;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Decode the state into the loop enable and the status outputs.
    always_comb begin
        loop_en  = (state_q == ST_CAL);
        busy     = (state_q == ST_CAL);
        cal_done = (state_q == ST_HOLD);
    end

    // Independent saturating tally of zero-error samples, used only by the check below.
    always_ff @(posedge clk) begin
        if (!rst_n || cal_start) begin
            zrun_q <= '0;
        end else if ((state_q == ST_CAL) && sample_valid) begin
            if (!err_zero)                    zrun_q <= '0;
            else if (zrun_q != {ZW{1'b1}})    zrun_q <= zrun_q + 1'b1;
        end
    end

    // R7
    done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> (zrun_q >= ZW'(WIN)));
    // R7
    done_on_zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(sample_valid && err_zero));
    // R6
    restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (busy && !cal_done));
endmodule

// File: rtl/dco_delay_path.sv
// Module: digital offset removal path.
// Delays each valid sample by DEPTH valid samples through a shift
// register and subtracts the current estimate from the delayed copy.
// The output is qualified once DEPTH samples have entered the line.
// Assumes: DEPTH >= 1.
module dco_delay_path #(
    parameter int DW    = 12,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic signed [DW-1:0] sample_in,
    input  logic signed [DW-1:0] est,
    output logic                 clean_valid,
    output logic signed [DW:0]   clean_out
);
    localparam int FW = $clog2(DEPTH + 1);

    logic signed [DW-1:0] line_q [DEPTH];
    logic [FW-1:0]        fill_q;
    logic                 filled;
    logic signed [DW-1:0] tap;

    // Select the oldest stage and tell whether it holds a real sample.
    always_comb begin
        tap    = line_q[DEPTH-1];
        filled = (fill_q == FW'(DEPTH));
    end

    // Shift the delay line on every valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else if (sample_valid) begin
            line_q[0] <= sample_in;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    // Count samples until the line is full, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fill_q <= '0;
        else if (sample_valid && !filled) fill_q <= fill_q + 1'b1;
    end

    // Register the corrected output and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_valid <= 1'b0;
            clean_out   <= '0;
        end else begin
            clean_valid <= sample_valid && filled;
            if (sample_valid) clean_out <= {tap[DW-1], tap} - {est[DW-1], est};
        end
    end

    // R9
    clean_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_valid |-> $past(sample_valid));
endmodule

// File: rtl/dc_offset_tracker.sv
// Module: top of the DC offset tracking loop.
// Connects the integrator, the calibration controller and the digital
// correction path. The estimate drives the DAC port directly, and a
// strobe marks each update.
// Assumes: shift_k is steady during calibration; cal_start is not
// coincident with a valid sample.
module dc_offset_tracker #(
    parameter int DW        = 12,
    parameter int SHIFT_MIN = 4,
    parameter int SHIFT_MAX = 12,
    parameter int SW        = 4,
    parameter int CAL_WIN   = 16,
    parameter int DELAY     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic signed [DW-1:0] sample_in,
    input  logic [SW-1:0]        shift_k,
    input  logic                 cal_start,
    output logic signed [DW-1:0] dac_code,
    output logic                 dac_update,
    output logic                 busy,
    output logic                 cal_done,
    output logic                 clean_valid,
    output logic signed [DW:0]   clean_out
);
    logic signed [DW-1:0] est;
    logic signed [DW:0]   err;
    logic                 err_zero;
    logic                 loop_en;
    logic                 upd;

    // Integer error of zero means the residual is below one LSB.
    always_comb begin
        err_zero   = (err == '0);
        dac_code   = est;
        dac_update = upd;
    end

    dco_loop_acc #(
        .DW(DW), .SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX), .SW(SW)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_in(sample_in), .shift_k(shift_k), .loop_en(loop_en),
        .est(est), .err(err), .upd(upd)
    );

    dco_cal_fsm #(.WIN(CAL_WIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .sample_valid(sample_valid), .err_zero(err_zero),
        .loop_en(loop_en), .busy(busy), .cal_done(cal_done)
    );

    dco_delay_path #(.DW(DW), .DEPTH(DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_in(sample_in), .est(est),
        .clean_valid(clean_valid), .clean_out(clean_out)
    );

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !cal_start) |=> (cal_done && $stable(dac_code)));
    // R4
    update_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |-> $past(busy && sample_valid));
    // R4
    no_update_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && $past(cal_done)) |-> !dac_update);
endmodule

// File: tb/dc_offset_tracker_bench.sv
module dc_offset_tracker_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sample_valid = 1'b0;
    logic signed [11:0] sample_in = '0;
    logic [3:0]         shift_k = 4'd4;
    logic               cal_start = 1'b0;
    logic signed [11:0] dac_code;
    logic               dac_update;
    logic               busy;
    logic               cal_done;
    logic               clean_valid;
    logic signed [12:0] clean_out;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Convergence table for R10: target level and gain shift per row.
    localparam int NTV = 6;
    localparam int TV_LVL [NTV] = '{150, -300, 2047, -2048, 7, 9};
    localparam int TV_SH  [NTV] = '{4, 6, 5, 4, 8, 12};

    always #2 clk = ~clk;

    dc_offset_tracker u_dc_offset_tracker (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_in(sample_in), .shift_k(shift_k), .cal_start(cal_start),
        .dac_code(dac_code), .dac_update(dac_update), .busy(busy),
        .cal_done(cal_done), .clean_valid(clean_valid), .clean_out(clean_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; return just after the rising edge.
    task automatic step(input int v, input bit vld, input bit cs);
        @(negedge clk);
        sample_in    = 12'(v);
        sample_valid = vld;
        cal_start    = cs;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int k);
        @(negedge clk);
        rst_n = 1'b0; sample_valid = 1'b0; cal_start = 1'b0; shift_k = 4'(k);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hist [4];
        // R5: reset state
        do_reset(0);
        #1;
        check(dac_code == 0, "R5", "dac_code", dac_code, 0);
        check(busy == 1'b1, "R5", "busy", busy, 1);
        check(cal_done == 1'b0, "R5", "cal_done", cal_done, 0);
        check(dac_update == 1'b0, "R5", "dac_update", dac_update, 0);
        check(clean_valid == 1'b0, "R5", "clean_valid", clean_valid, 0);

        // R1, R2: shift 0 clamps to 4: 1600*256/4096 = 100
        step(1600, 1, 0);
        check(dac_code == 100, "R2", "clamped low shift", dac_code, 100);
        check(dac_update == 1'b1, "R4", "strobe after sample", dac_update, 1);
        step(0, 0, 0);
        check(dac_update == 1'b0, "R4", "strobe one cycle", dac_update, 0);

        // R1: shift 8: 1600*16/4096 = 6.25 -> 6
        do_reset(8);
        step(1600, 1, 0);
        check(dac_code == 6, "R1", "shift 8 step", dac_code, 6);

        // R2: shift 15 clamps to 12; R9 fill boundary
        do_reset(15);
        step(1600, 1, 0);
        step(1600, 1, 0);
        check(dac_code == 0, "R2", "clamped high shift, two samples", dac_code, 0);
        step(1600, 1, 0);
        check(dac_code == 1, "R2", "clamped high shift, three samples", dac_code, 1);
        check(clean_valid == 1'b0, "R9", "not valid before fill", clean_valid, 0);
        step(1600, 1, 0);
        check(clean_valid == 1'b0, "R9", "not valid on fourth", clean_valid, 0);
        step(1600, 1, 0);
        check(clean_valid == 1'b1, "R9", "valid on fifth", clean_valid, 1);
        check(clean_out == 1599, "R9", "first clean value", clean_out, 1599);

        // R10 and R3: table of convergence targets
        for (int r = 0; r < NTV; r++) begin
            int start;
            int prev;
            int cnt;
            int bad;
            shift_k = 4'(TV_SH[r]);
            step(0, 0, 1);
            check(busy == 1'b1 && cal_done == 1'b0, "R6", "restart on command", busy, 1);
            start = dac_code; prev = start; cnt = 0; bad = 0;
            while (!cal_done && cnt < 20000) begin
                step(TV_LVL[r], 1, 0);
                if (TV_LVL[r] > start && dac_code < prev) bad++;
                if (TV_LVL[r] < start && dac_code > prev) bad++;
                prev = dac_code;
                cnt++;
            end
            check(bad == 0, "R3", "monotonic approach, no wrap", bad, 0);
            check(cal_done == 1'b1, "R10", "calibration completed", cal_done, 1);
            check(dac_code == TV_LVL[r], "R10", "converged code", dac_code, TV_LVL[r]);
            check(busy == 1'b0, "R7", "busy clear when done", busy, 0);
        end

        // R8 and R9: frozen estimate 9, ramp through the delayed path
        for (int i = 0; i < 4; i++) hist[i] = 9;
        for (int i = 0; i < 12; i++) begin
            int v;
            int exp;
            v = 500 + 37 * i;
            exp = hist[3] - 9;
            for (int j = 3; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = v;
            step(v, 1, 0);
            check(dac_code == 9, "R8", "frozen estimate", dac_code, 9);
            check(dac_update == 1'b0, "R4", "no strobe in hold", dac_update, 0);
            check(cal_done == 1'b1, "R8", "done held", cal_done, 1);
            check(clean_valid == 1'b1, "R9", "clean valid", clean_valid, 1);
            check(clean_out == exp, "R9", "clean value", clean_out, exp);
        end

        // R7: exact window of 16 zero-error samples
        shift_k = 4'd12;
        step(0, 0, 1);
        for (int i = 0; i < 15; i++) step(9, 1, 0);
        check(cal_done == 1'b0, "R7", "not done after 15", cal_done, 0);
        step(9, 1, 0);
        check(cal_done == 1'b1, "R7", "done after 16", cal_done, 1);

        // R7: a nonzero error restarts the count
        step(0, 0, 1);
        for (int i = 0; i < 10; i++) step(9, 1, 0);
        step(10, 1, 0);
        for (int i = 0; i < 15; i++) step(9, 1, 0);
        check(cal_done == 1'b0, "R7", "count restarted", cal_done, 0);
        step(9, 1, 0);
        check(cal_done == 1'b1, "R7", "done after fresh 16", cal_done, 1);
        check(dac_code == 9, "R1", "sub-LSB step keeps code", dac_code, 9);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule